// File: doc/BRIEF.md
# Smart-Card Character Transmitter with NACK-Driven Retry

This block sends one character at a time on a half-duplex smart-card style I/O line. A character is a frame made of a low start bit, eight data bits sent least significant bit first, and an even parity bit. The block drives the line only during the frame. After the parity bit it releases the line for a guard period. Near the middle of the first guard bit it samples the line. A low level there means the far end has refused the character (a NACK).

When the retry limit sampled at acceptance is above zero, a refused character is sent again. The new start bit follows directly after the guard period. Each refusal costs one repetition, and the limit allows at most seven repetitions, so a character goes out eight times at most. An accepted transmission, or one more refusal once the limit is used up, ends the character. The block then asks for the next holding value. A sticky flag reports that a character used up its whole repetition allowance, and a one-cycle control pulse clears it.

Timing is derived from an external tick enable. Each bit lasts OVS ticks. Baud-rate generation and reception are done elsewhere.

Top module: `sc_rep_tx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, tx_ready is 1, ser_oe is 0, ser_out is 1 and iter_flag is 0.
- R2: An accepted character is driven with ser_oe high as a frame of DATA_W+2 bits, each lasting OVS bit_en ticks. The frame is a start bit of 0, then data bits from bit 0 upward, then a parity bit that makes the count of ones over data and parity even.
- R3: After the parity bit, ser_oe is low for GUARD bit times. The transmission counts as refused only if line_in is low at tick OVS/2 of the first guard bit.
- R4: With max_iter equal to 0, every character is sent exactly once, whatever the line shows in the guard period, and iter_flag is not set.
- R5: max_iter is captured when a character is accepted. While the number of repetitions already made is below that value, a refused transmission is followed at once, after its guard period, by a new frame of the same character. A character therefore goes out at most max_iter+1 times, and never more than eight.
- R6: A transmission that is not refused ends the character. The repetition count restarts at zero, so the next character gets its full allowance again.
- R7: iter_flag goes to 1 when the repetition count reaches the captured max_iter. It stays at 1 even if that repetition is then accepted.
- R8: A cycle with rst_iter high makes iter_flag 0 on the next cycle. This takes priority over a simultaneous set.
- R9: If the final allowed repetition is also refused, the character is dropped and the block returns to ready for the next holding value.
- R10: tx_ready is 1 only while no character is in progress. A character is taken on a cycle with tx_valid and tx_ready both high, and tx_ready stays 0 from then until the character is accepted by the far end or dropped.
- R11: Frame and guard timing advance only on cycles with bit_en high. While bit_en is low during a character, ser_out and ser_oe hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Tick enable; OVS ticks make one bit time |
| tx_data | input | DATA_W | Holding value to transmit |
| tx_valid | input | 1 | Holding value present |
| tx_ready | output | 1 | Block idle, holding value is taken this cycle if valid |
| max_iter | input | ITER_W | Repetition limit, captured at acceptance; 0 disables retry |
| rst_iter | input | 1 | Pulse that clears iter_flag |
| line_in | input | 1 | Sampled level of the shared I/O line |
| ser_out | output | 1 | Serial data driven toward the line |
| ser_oe | output | 1 | Output enable; high only during a frame |
| iter_flag | output | 1 | Sticky: a character used its whole repetition allowance |

## Verification
Some behaviours are checked on every cycle by properties. The repetition count never exceeds the captured limit and stays at zero when retry is off. The status flag rises only when the count equals a nonzero limit, and it falls after a clear pulse. Every frame begins with a low start bit, the line is released after the parity bit, and the outputs hold while the tick enable is low. Other behaviours only the bench scenarios can show. These are the number of transmissions for each refusal pattern, the bit order and parity of every repeated frame, and the counter restart between characters. They also include dropping a character after its last refusal, and the freeze and resume of a frame under a stalled tick enable.

// File: rtl/sc_rep_pkg.sv
package sc_rep_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GUARD = 2'd2
   } sc_state_e;
endpackage

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
   parameter int OVS   = 4,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             run,
   input  logic             clr,
   output logic             bit_end,
   output logic             mid_hit,
   output logic [CNT_W-1:0] bit_idx
);
   localparam int TW  = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int MID = OVS / 2;

   logic [TW-1:0] tick_q;
   logic          tick_last;

   assign tick_last = (tick_q == TW'(OVS - 1));
   assign bit_end   = run && bit_en && tick_last;
   assign mid_hit   = run && bit_en && (tick_q == TW'(MID));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q  <= '0;
         bit_idx <= '0;
      end else if (clr) begin
         tick_q  <= '0;
         bit_idx <= '0;
      end else if (run && bit_en) begin
         if (tick_last) begin
            tick_q  <= '0;
            bit_idx <= bit_idx + 1'b1;
         end else begin
            tick_q  <= tick_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sc_frame_mux.sv
module sc_frame_mux #(
   parameter int DATA_W  = 8,
   parameter int ODD_PAR = 0,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  bit_idx,
   output logic              frame_bit
);
   localparam int FRAME_BITS = DATA_W + 2;

   logic [DATA_W-1:0]     data_q;
   logic                  par_bit;
   logic [FRAME_BITS-1:0] frame_v;
   logic [FRAME_BITS-1:0] frame_sh;

   always_ff @(posedge clk) begin
      if (!rst_n)    data_q <= '0;
      else if (load) data_q <= din;
   end

   generate
      if (ODD_PAR != 0) begin : g_odd
         assign par_bit = ~(^data_q);
      end else begin : g_even
         assign par_bit = ^data_q;
      end
   endgenerate

   assign frame_v   = {par_bit, data_q, 1'b0};
   assign frame_sh  = frame_v >> bit_idx;
   assign frame_bit = frame_sh[0];
endmodule

// File: rtl/sc_rep_ctrl.sv
module sc_rep_ctrl #(
   parameter int ITER_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ITER_W-1:0] max_iter,
   input  logic              fin,
   input  logic              nack,
   input  logic              rst_iter,
   output logic              retry,
   output logic              iter_flag
);
   logic [ITER_W-1:0] mi_q;
   logic [ITER_W-1:0] rep_cnt;
   logic [ITER_W-1:0] rep_nxt;
   logic              hit_limit;

   assign retry     = nack && (rep_cnt < mi_q);
   assign rep_nxt   = ITER_W'(rep_cnt + 1'b1);
   assign hit_limit = fin && retry && (rep_nxt == mi_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mi_q    <= '0;
         rep_cnt <= '0;
      end else if (load) begin
         mi_q    <= max_iter;
         rep_cnt <= '0;
      end else if (fin) begin
         rep_cnt <= retry ? rep_nxt : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         iter_flag <= 1'b0;
      else if (rst_iter)  iter_flag <= 1'b0;
      else if (hit_limit) iter_flag <= 1'b1;
   end

   // R5
   rep_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rep_cnt <= mi_q);

   // R4
   no_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mi_q == '0) |-> (rep_cnt == '0));

   // R7
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iter_flag) |-> ((mi_q != '0) && (rep_cnt == mi_q)));

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_iter |=> !iter_flag);
endmodule

// File: rtl/sc_rep_tx.sv
module sc_rep_tx
   import sc_rep_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ITER_W  = 3,
   parameter int OVS     = 4,
   parameter int GUARD   = 2,
   parameter int ODD_PAR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [ITER_W-1:0] max_iter,
   input  logic              rst_iter,
   input  logic              line_in,
   output logic              ser_out,
   output logic              ser_oe,
   output logic              iter_flag
);
   localparam int FRAME_BITS = DATA_W + 2;
   localparam int CNT_MAX    = (FRAME_BITS > GUARD) ? FRAME_BITS : GUARD;
   localparam int CNT_W      = $clog2(CNT_MAX + 1);

   generate
      if (OVS < 3) begin : g_bad_ovs
         $error("sc_rep_tx: OVS must be at least 3");
      end
      if (GUARD < 1) begin : g_bad_guard
         $error("sc_rep_tx: GUARD must be at least 1");
      end
      if (ITER_W < 1 || ITER_W > 3) begin : g_bad_iter
         $error("sc_rep_tx: ITER_W must be 1 to 3");
      end
   endgenerate

   sc_state_e        state_q;
   logic             load, run, clr;
   logic             bit_end, mid_hit;
   logic [CNT_W-1:0] bit_idx;
   logic             frame_done, guard_mid, fin;
   logic             nack_q, retry, frame_bit;

   assign tx_ready   = (state_q == ST_IDLE);
   assign load       = tx_ready && tx_valid;
   assign run        = (state_q != ST_IDLE);
   assign frame_done = (state_q == ST_FRAME) && bit_end &&
                       (bit_idx == CNT_W'(FRAME_BITS - 1));
   assign guard_mid  = (state_q == ST_GUARD) && mid_hit && (bit_idx == '0);
   assign fin        = (state_q == ST_GUARD) && bit_end &&
                       (bit_idx == CNT_W'(GUARD - 1));
   assign clr        = load || frame_done || fin;

   sc_bit_timer #(.OVS(OVS), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .run(run), .clr(clr),
      .bit_end(bit_end), .mid_hit(mid_hit), .bit_idx(bit_idx)
   );

   sc_frame_mux #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR), .CNT_W(CNT_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .load(load), .din(tx_data),
      .bit_idx(bit_idx), .frame_bit(frame_bit)
   );

   sc_rep_ctrl #(.ITER_W(ITER_W)) u_rep (
      .clk(clk), .rst_n(rst_n), .load(load), .max_iter(max_iter),
      .fin(fin), .nack(nack_q), .rst_iter(rst_iter),
      .retry(retry), .iter_flag(iter_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  if (load)       state_q <= ST_FRAME;
            ST_FRAME: if (frame_done) state_q <= ST_GUARD;
            ST_GUARD: if (fin)        state_q <= retry ? ST_FRAME : ST_IDLE;
            default:                  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          nack_q <= 1'b0;
      else if (frame_done) nack_q <= 1'b0;
      else if (guard_mid)  nack_q <= ~line_in;
   end

   assign ser_oe  = (state_q == ST_FRAME);
   assign ser_out = ser_oe ? frame_bit : 1'b1;

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_oe) |-> !ser_out);

   // R3
   guard_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !ser_oe);

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !tx_ready) |=> ($stable(ser_out) && $stable(ser_oe)));

   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_oe |-> !tx_ready);
endmodule

// File: tb/sim_sc_rep_tx.sv
`timescale 1ns/1ps
module sim_sc_rep_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b1;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic [2:0] max_iter = 3'd0;
   logic       rst_iter = 1'b0;
   logic       tx_ready, ser_out, ser_oe, iter_flag, line_in;

   int         n_chk = 0;
   int         n_bad = 0;
   logic [7:0] nack_mask = 8'h00;
   logic [3:0] fcnt = 4'd0;
   logic       cur_nack = 1'b0;
   logic       mon_en = 1'b1;
   logic       done = 1'b0;
   logic [7:0] rec_d [8];
   logic       rec_ok [8];

   // data[27:20] limit[18:16] refusal mask[15:8] sends[7:4] flag[0]
   localparam logic [27:0] VEC [9] = '{
      28'hA5_0_00_1_0,
      28'h3C_0_FF_1_0,
      28'h5A_3_01_2_0,
      28'h81_3_07_4_1,
      28'h7E_3_FF_4_1,
      28'hFF_7_FF_8_1,
      28'h00_7_3F_7_0,
      28'h96_1_01_2_1,
      28'hC3_2_02_1_0
   };

   always #2 clk = ~clk;

   assign line_in = ser_oe ? ser_out : ~cur_nack;

   sc_rep_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .max_iter(max_iter),
      .rst_iter(rst_iter), .line_in(line_in), .ser_out(ser_out),
      .ser_oe(ser_oe), .iter_flag(iter_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // far-end model: refuses the n-th transmission when mask bit n is set
   always begin : mon
      logic [9:0] b;
      @(posedge ser_oe);
      cur_nack = nack_mask[fcnt[2:0]];
      if (mon_en) begin
         @(negedge clk);
         @(negedge clk);
         b[0] = ser_out;
         for (int k = 1; k < 10; k++) begin
            repeat (4) @(negedge clk);
            b[k] = ser_out;
         end
         repeat (4) @(negedge clk);
         if (fcnt < 4'd8) begin
            rec_d[fcnt[2:0]]  = b[8:1];
            rec_ok[fcnt[2:0]] = (b[0] == 1'b0) && ((^b[9:1]) == 1'b0) && !ser_oe;
         end
      end
      fcnt = fcnt + 4'd1;
   end

   task automatic run_char(input logic [7:0] d, input logic [2:0] mi,
                           input logic [7:0] m, input int en, input int ef,
                           input string tag);
      @(negedge clk);
      max_iter = mi; nack_mask = m; fcnt = 4'd0; cur_nack = 1'b0;
      rst_iter = 1'b1;
      @(negedge clk);
      rst_iter = 1'b0;
      chk({tag, " R8 flag cleared before char"}, int'(iter_flag), 0);
      tx_data = d; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk({tag, " R10 ready low while busy"}, int'(tx_ready), 0);
      while (!tx_ready) @(negedge clk);
      chk({tag, (mi == 3'd0) ? " R4 send count" : " R5 R6 R9 send count"},
          int'(fcnt), en);
      for (int k = 0; k < en && k < 8; k++) begin
         chk({tag, " R2 frame data"}, int'(rec_d[k]), int'(d));
         chk({tag, " R2 R3 start/parity/release"}, int'(rec_ok[k]), 1);
      end
      chk({tag, " R7 iteration flag"}, int'(iter_flag), ef);
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", int'(tx_ready), 1);
      chk("R1 oe in reset", int'(ser_oe), 0);
      chk("R1 out in reset", int'(ser_out), 1);
      chk("R1 flag in reset", int'(iter_flag), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", int'(tx_ready), 1);
      chk("R1 oe after reset", int'(ser_oe), 0);

      // R6: consecutive entries show the count restarting per character
      for (int i = 0; i < 9; i++) begin
         run_char(VEC[i][27:20], VEC[i][18:16], VEC[i][15:8],
                  int'(VEC[i][7:4]), int'(VEC[i][0]), $sformatf("vec%0d", i));
      end

      // R8: explicit clear of a set flag while idle
      run_char(8'h42, 3'd1, 8'hFF, 2, 1, "dirA");
      @(negedge clk);
      rst_iter = 1'b1;
      @(negedge clk);
      rst_iter = 1'b0;
      chk("R8 flag cleared by pulse", int'(iter_flag), 0);

      // R11: stalled tick enable freezes the frame
      @(negedge clk);
      mon_en = 1'b0; bit_en = 1'b0; max_iter = 3'd0; nack_mask = 8'h00;
      fcnt = 4'd0; cur_nack = 1'b0; tx_data = 8'h55; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk("R11 oe held during stall", int'(ser_oe), 1);
      chk("R11 start bit held during stall", int'(ser_out), 0);
      chk("R11 ready low during stall", int'(tx_ready), 0);
      bit_en = 1'b1;
      repeat (4) @(negedge clk);
      bit_en = 1'b0;
      repeat (6) @(negedge clk);
      chk("R11 R2 one bit advanced to D0", int'(ser_out), 1);
      chk("R11 oe still high", int'(ser_oe), 1);
      bit_en = 1'b1;
      while (!tx_ready) @(negedge clk);
      chk("R11 R4 single send after stall", int'(fcnt), 1);
      mon_en = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule